// File: doc/BRIEF.md
# Read Address Burst Coalescer

This block accepts a stream of word-aligned read byte addresses and folds runs of them into burst descriptors. Each descriptor holds a base address, a word count and a burst kind. A remote host pays one command round trip per descriptor instead of one per word, which matters when the link is slow.

Two kinds of run are recognised. An incrementing run is a sequence of addresses that each sit one word above the previous one. A fixed run is the same address repeated. Merging into incrementing runs is always on. Merging into fixed runs is on only while `cfg_fixed_en` is high.

A burst that holds one word has no kind yet. The second address decides the kind, and the fixed test is made before the incrementing test. Bursts are capped at `MAX_LEN` words. When the input marks its last address, the pending burst is flushed. Descriptors leave in input order, and a stalled output holds the input back.

Top module: `burst_coalescer`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: An address equal to base + WORD_BYTES × current length extends the pending burst as incrementing (`out_fixed` = 0), provided the burst is one word long or is already incrementing.
- R3: While `cfg_fixed_en` is 1, an address equal to the pending base extends the burst as fixed (`out_fixed` = 1), provided the burst is one word long or is already fixed. This test is applied before the incrementing test, so a fixed descriptor always has a length of at least 2.
- R4: While `cfg_fixed_en` is 0, repeated identical addresses are never merged. Each one yields its own one-word incrementing descriptor.
- R5: Once a burst is longer than one word, its kind is locked. An address that matches only the other kind does not extend it.
- R6: A burst never exceeds `MAX_LEN` words (default 256). When a burst is full, the next address starts a new burst even if it would otherwise match.
- R7: An address that cannot be merged causes the pending burst to be emitted, and that address becomes the base of a new one-word incrementing burst.
- R8: The input beat marked by `in_last` ends the list. The burst pending after it is always emitted, so a non-merging last address yields two descriptors. No merging happens across lists.
- R9: While `out_valid` is 1 and `out_ready` is 0, the descriptor stays stable and `in_ready` is 0. No address is lost or reordered.
- R10: Descriptors appear in input order. `out_len` is the word count, from 1 to `MAX_LEN`, in `$clog2(MAX_LEN+1)` bits. `out_base` is the byte address of the first word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_fixed_en | input | 1 | 1 allows fixed (same-address) merging |
| in_valid | input | 1 | Address beat valid |
| in_ready | output | 1 | Address beat accepted when high with in_valid |
| in_addr | input | AW | Word-aligned byte address |
| in_last | input | 1 | Marks the final address of a list |
| out_valid | output | 1 | Descriptor valid |
| out_ready | input | 1 | Descriptor consumer ready |
| out_base | output | AW | Byte address of the first word of the burst |
| out_len | output | LW | Word count, 1 to MAX_LEN |
| out_fixed | output | 1 | 1 = fixed burst, 0 = incrementing burst |

## Verification
The assertions check on every cycle that a descriptor is held stable under a stall and that the input is blocked while it is held. They also check that every emitted length lies between 1 and `MAX_LEN`, and that a fixed descriptor is never shorter than two words. Only the bench scenarios can show the merge decisions themselves: which address joins which burst, kind locking, the cap at `MAX_LEN`, and the flush on the last address. The bench compares whole descriptor sequences for every four-address list drawn from a three-address alphabet, with fixed merging both on and off, and under a pseudo-random output stall.

// File: rtl/burst_coal_pkg.sv
package burst_coal_pkg;

    typedef enum logic {
        KIND_INCR  = 1'b0,
        KIND_FIXED = 1'b1
    } burst_kind_e;

    typedef enum logic [1:0] {
        ACT_START     = 2'd0,
        ACT_JOIN_FIX  = 2'd1,
        ACT_JOIN_INC  = 2'd2,
        ACT_SPLIT     = 2'd3
    } merge_act_e;

endpackage

// File: rtl/merge_judge.sv
module merge_judge
    import burst_coal_pkg::*;
#(
    parameter int AW         = 32,
    parameter int LW         = 9,
    parameter int MAX_LEN    = 256,
    parameter int WORD_SHIFT = 2
) (
    input  logic        pend_valid,
    input  logic [AW-1:0] pend_base,
    input  logic [LW-1:0] pend_len,
    input  burst_kind_e pend_kind,
    input  logic        fix_en,
    input  logic [AW-1:0] addr,
    output merge_act_e  act
);
    localparam logic [LW-1:0] LEN_CAP = LW'(MAX_LEN);

    logic          single;
    logic          room;
    logic [AW-1:0] next_inc;
    logic          fix_hit;
    logic          inc_hit;

    always_comb begin
        single   = (pend_len == LW'(1));
        room     = (pend_len < LEN_CAP);
        next_inc = pend_base + (AW'(pend_len) << WORD_SHIFT);
        fix_hit  = fix_en && room && (single || pend_kind == KIND_FIXED)
                   && (addr == pend_base);
        inc_hit  = room && (single || pend_kind == KIND_INCR)
                   && (addr == next_inc);
        if (!pend_valid)   act = ACT_START;
        else if (fix_hit)  act = ACT_JOIN_FIX;
        else if (inc_hit)  act = ACT_JOIN_INC;
        else               act = ACT_SPLIT;
    end
endmodule

// File: rtl/desc_slot.sv
module desc_slot
    import burst_coal_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] ld_base,
    input  logic [LW-1:0] ld_len,
    input  burst_kind_e   ld_kind,
    input  logic          take,
    output logic          free,
    output logic          valid,
    output logic [AW-1:0] base,
    output logic [LW-1:0] len,
    output burst_kind_e   kind
);
    typedef struct packed {
        logic          valid;
        logic [AW-1:0] base;
        logic [LW-1:0] len;
        burst_kind_e   kind;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        free   = !slot_q.valid || take;
        if (slot_q.valid && take) slot_d.valid = 1'b0;
        if (load) begin
            slot_d.valid = 1'b1;
            slot_d.base  = ld_base;
            slot_d.len   = ld_len;
            slot_d.kind  = ld_kind;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign valid = slot_q.valid;
    assign base  = slot_q.base;
    assign len   = slot_q.len;
    assign kind  = slot_q.kind;
endmodule

// File: rtl/burst_coalescer.sv
module burst_coalescer
    import burst_coal_pkg::*;
#(
    parameter int AW         = 32,
    parameter int MAX_LEN    = 256,
    parameter int WORD_BYTES = 4,
    localparam int LW        = $clog2(MAX_LEN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_fixed_en,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [AW-1:0] in_addr,
    input  logic          in_last,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [AW-1:0] out_base,
    output logic [LW-1:0] out_len,
    output logic          out_fixed
);
    localparam int WSH = $clog2(WORD_BYTES);

    typedef struct packed {
        logic          valid;
        logic          flush;
        logic [AW-1:0] base;
        logic [LW-1:0] len;
        burst_kind_e   kind;
    } pend_t;

    pend_t         pend_d, pend_q;
    merge_act_e    act;
    logic          slot_free;
    logic          load;
    logic [AW-1:0] ld_base;
    logic [LW-1:0] ld_len;
    burst_kind_e   ld_kind;
    burst_kind_e   slot_kind;
    logic [AW-1:0] nb_base;
    logic [LW-1:0] nb_len;
    burst_kind_e   nb_kind;

    merge_judge #(
        .AW(AW), .LW(LW), .MAX_LEN(MAX_LEN), .WORD_SHIFT(WSH)
    ) u_judge (
        .pend_valid (pend_q.valid),
        .pend_base  (pend_q.base),
        .pend_len   (pend_q.len),
        .pend_kind  (pend_q.kind),
        .fix_en     (cfg_fixed_en),
        .addr       (in_addr),
        .act        (act)
    );

    always_comb begin
        pend_d   = pend_q;
        load     = 1'b0;
        ld_base  = pend_q.base;
        ld_len   = pend_q.len;
        ld_kind  = pend_q.kind;
        in_ready = slot_free && !pend_q.flush;
        nb_base  = in_addr;
        nb_len   = LW'(1);
        nb_kind  = KIND_INCR;

        case (act)
            ACT_JOIN_FIX: begin
                nb_base = pend_q.base;
                nb_len  = pend_q.len + LW'(1);
                nb_kind = KIND_FIXED;
            end
            ACT_JOIN_INC: begin
                nb_base = pend_q.base;
                nb_len  = pend_q.len + LW'(1);
                nb_kind = KIND_INCR;
            end
            default: ;
        endcase

        if (pend_q.flush) begin
            if (slot_free) begin
                load         = 1'b1;
                pend_d.valid = 1'b0;
                pend_d.flush = 1'b0;
            end
        end else if (in_valid && in_ready) begin
            // a split hands the old burst to the slot first
            if (act == ACT_SPLIT) load = 1'b1;
            if (in_last && act != ACT_SPLIT) begin
                load         = 1'b1;
                ld_base      = nb_base;
                ld_len       = nb_len;
                ld_kind      = nb_kind;
                pend_d.valid = 1'b0;
            end else begin
                pend_d.valid = 1'b1;
                pend_d.flush = in_last;
                pend_d.base  = nb_base;
                pend_d.len   = nb_len;
                pend_d.kind  = nb_kind;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    desc_slot #(.AW(AW), .LW(LW)) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .ld_base (ld_base),
        .ld_len  (ld_len),
        .ld_kind (ld_kind),
        .take    (out_ready),
        .free    (slot_free),
        .valid   (out_valid),
        .base    (out_base),
        .len     (out_len),
        .kind    (slot_kind)
    );

    assign out_fixed = (slot_kind == KIND_FIXED);
endmodule

// File: rtl/burst_coalescer_chk.sv
module burst_coalescer_chk #(
    parameter int AW      = 32,
    parameter int MAX_LEN = 256,
    parameter int LW      = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_ready,
    input logic          out_valid,
    input logic          out_ready,
    input logic [AW-1:0] out_base,
    input logic [LW-1:0] out_len,
    input logic          out_fixed
);
    // R9: a stalled descriptor is held unchanged
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_base) && $stable(out_len) && $stable(out_fixed)));

    // R9: a stalled output blocks the address input
    p_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R10: word count within 1..MAX_LEN
    p_len_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_len >= LW'(1) && out_len <= LW'(MAX_LEN)));

    // R3: fixed kind only comes from a merge
    p_fixed_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_fixed) |-> (out_len >= LW'(2)));
endmodule

bind burst_coalescer burst_coalescer_chk #(
    .AW(AW), .MAX_LEN(MAX_LEN), .LW(LW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_base  (out_base),
    .out_len   (out_len),
    .out_fixed (out_fixed)
);

// File: tb/tb_burst_coalescer.sv
module tb_burst_coalescer;
    localparam int AW = 32;
    localparam int MAXL = 256;
    localparam int LW = $clog2(MAXL + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_fixed_en = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [AW-1:0] in_addr = '0;
    logic in_last = 1'b0;
    logic out_valid;
    logic out_ready = 1'b1;
    logic [AW-1:0] out_base;
    logic [LW-1:0] out_len;
    logic out_fixed;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic stall_en = 1'b0;
    logic [7:0] lfsr = 8'hA5;

    logic [AW-1:0] list[$];
    logic [AW-1:0] exp_b[$];
    int            exp_l[$];
    logic          exp_f[$];
    logic [AW-1:0] got_b[$];
    int            got_l[$];
    logic          got_f[$];

    burst_coalescer #(.AW(AW), .MAX_LEN(MAXL), .WORD_BYTES(4)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_fixed_en(cfg_fixed_en),
        .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
        .in_last(in_last), .out_valid(out_valid), .out_ready(out_ready),
        .out_base(out_base), .out_len(out_len), .out_fixed(out_fixed)
    );

    always #5 clk = ~clk;

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected below 150000", cyc);
            summary();
        end
    end

    // sink: sets out_ready at each falling edge, records handshakes
    always @(negedge clk) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        out_ready = stall_en ? (lfsr[0] | lfsr[2]) : 1'b1;
        #1;
        if (rst_n && out_valid && out_ready) begin
            got_b.push_back(out_base);
            got_l.push_back(int'(out_len));
            got_f.push_back(out_fixed);
        end
    end

    task automatic chk(input string req, input logic ok, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, expv);
        end
    endtask

    // expected descriptors, built from the merge rules R2..R8
    task automatic model(input logic fe);
        logic [AW-1:0] b;
        int l;
        logic k;
        exp_b.delete(); exp_l.delete(); exp_f.delete();
        b = list[0]; l = 1; k = 1'b0;
        for (int i = 1; i < list.size(); i++) begin
            logic m;
            m = 1'b0;
            if (fe && (l == 1 || k) && list[i] == b && l < MAXL) begin
                k = 1'b1; l++; m = 1'b1;
            end else if ((l == 1 || !k) && list[i] == b + AW'(4 * l) && l < MAXL) begin
                k = 1'b0; l++; m = 1'b1;
            end
            if (!m) begin
                exp_b.push_back(b); exp_l.push_back(l); exp_f.push_back(k);
                b = list[i]; l = 1; k = 1'b0;
            end
        end
        exp_b.push_back(b); exp_l.push_back(l); exp_f.push_back(k);
    endtask

    task automatic run_list(input string req, input logic fe, input logic stall);
        int t;
        model(fe);
        got_b.delete(); got_l.delete(); got_f.delete();
        @(negedge clk);
        cfg_fixed_en = fe;
        stall_en = stall;
        for (int i = 0; i < list.size(); i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_addr = list[i];
            in_last = (i == list.size() - 1);
            #2;
            while (!in_ready) begin
                @(negedge clk);
                #2;
            end
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last = 1'b0;
        t = 0;
        while (got_b.size() < exp_b.size() && t < 3000) begin
            @(negedge clk);
            t++;
        end
        repeat (6) @(negedge clk);
        chk(req, got_b.size() == exp_b.size(), "descriptor count",
            got_b.size(), exp_b.size());
        for (int i = 0; i < exp_b.size() && i < got_b.size(); i++) begin
            chk(req, got_b[i] == exp_b[i], "base", got_b[i], exp_b[i]);
            chk(req, got_l[i] == exp_l[i], "len", got_l[i], exp_l[i]);
            chk(req, got_f[i] == exp_f[i], "fixed", got_f[i], exp_f[i]);
        end
        stall_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", out_valid == 1'b0, "out_valid in reset", out_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        chk("R1", out_valid == 1'b0, "out_valid after reset", out_valid, 0);
        chk("R1", in_ready == 1'b1, "in_ready after reset", in_ready, 1);

        // R2 R3 R7: mixed incrementing and fixed runs, explicit values
        list = '{32'h0, 32'h4, 32'h10, 32'h14, 32'h20, 32'h20};
        run_list("R2/R3/R7", 1'b1, 1'b0);
        chk("R3", got_b.size() == 3 && got_f[2] == 1'b1 && got_l[2] == 2,
            "third descriptor fixed len 2", got_b.size(), 3);

        // R4: fixed merging off
        list = '{32'h8, 32'h8, 32'h8};
        run_list("R4", 1'b0, 1'b0);
        chk("R4", got_b.size() == 3, "three single-word bursts", got_b.size(), 3);

        // R5: kind lock
        list = '{32'h0, 32'h4, 32'h0};
        run_list("R5", 1'b1, 1'b0);
        list = '{32'h8, 32'h8, 32'hC};
        run_list("R5", 1'b1, 1'b0);
        chk("R5", got_b.size() == 2 && got_b[1] == 32'hC, "incr after fixed splits",
            got_b.size(), 2);

        // R6: cap at MAX_LEN, incrementing and fixed
        list.delete();
        for (int i = 0; i < 300; i++) list.push_back(32'h1000 + 32'(4 * i));
        run_list("R6", 1'b1, 1'b0);
        chk("R6", got_l.size() == 2 && got_l[0] == MAXL && got_l[1] == 44,
            "incr split at cap", got_l.size() > 0 ? got_l[0] : 0, MAXL);
        list.delete();
        for (int i = 0; i < 260; i++) list.push_back(32'h40);
        run_list("R6", 1'b1, 1'b1);

        // R8: single-address list and non-merging last address
        list = '{32'h30};
        run_list("R8", 1'b1, 1'b0);
        list = '{32'h0, 32'h40};
        run_list("R8", 1'b1, 1'b0);
        list = '{32'h44, 32'h48};
        run_list("R8", 1'b1, 1'b0);
        chk("R8", got_b.size() == 1 && got_b[0] == 32'h44, "fresh list, no cross-list merge",
            got_b.size() > 0 ? got_b[0] : 0, 32'h44);

        // R9 R10 with R2 R3 R4 R5 R7: all 4-address lists over {0,4,8}
        for (int c = 0; c < 81; c++) begin
            for (int fe = 0; fe < 2; fe++) begin
                int v;
                v = c;
                list.delete();
                for (int j = 0; j < 4; j++) begin
                    list.push_back(32'(4 * (v % 3)));
                    v = v / 3;
                end
                run_list("R9/R10 sweep R2 R3 R4 R5 R7", fe[0], c[0]);
            end
        end
        summary();
    end
endmodule